// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a memory-mapped watchdog peripheral. A down-counter, advanced by a qualifying core tick, runs from a programmable load value. The first time it expires it raises an interrupt and restarts from the load value. If software does not service that interrupt before the next expiry, the block asks the system for a reset, so the full reset window is two load periods.

Every register except the key register is write-protected. A 32-bit magic key must be written before software can change the load value, the control bits or clear the interrupt, and any other value written to the key register locks the block again. Reads are never blocked. Software services the watchdog by unlocking, writing the clear register (which also restarts the count) and re-locking.

The register bus is a simple single-cycle strobe interface: a write is taken on the clock edge where `regWe` is high, and read data is a combinational function of `regAddr`.

Top module: `guard_timer`

## Requirements
- R1: The block leaves reset locked. A write of 0x1ACCE551 to the key register (address 0xC00) unlocks it, and a write of any other value there locks it. The key register reads 1 while locked and 0 while unlocked.
- R2: While locked, writes to the load, control and clear registers and to unmapped addresses change nothing; reads still return current values.
- R3: Register addresses are load 0x000, live count 0x004, control 0x008, clear 0x00C, status 0x014. Control bit 0 is run (counting and interrupt), control bit 1 is reset enable. Status bit 0 is the pending interrupt. The clear register and unmapped addresses read 0.
- R4: A tick while running with the count at zero is an expiry. With no interrupt pending, an expiry sets the interrupt and reloads the count from the load register.
- R5: An unlocked write to the clear register with bit 0 set clears the pending interrupt and reloads the count from the load register, taking priority over a tick in the same cycle. Bit 0 clear has no effect.
- R6: An expiry while the interrupt is already pending and reset is enabled drives the reset request high for exactly one cycle (or holds it until system reset when the hold parameter is set) and reloads the count. With reset disabled it only reloads.
- R7: With run cleared the count holds its value; setting run again resumes from that held value.
- R8: A write to the load register does not alter the running count; it is used at the next reload or clear.
- R9: While running and not at zero, each cycle with the tick high lowers the count by one; cycles without a tick leave it unchanged.
- R10: After reset, load and count are 0xFFFFFFFF, control is 0, and interrupt and reset request are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter tick qualifier |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| irqOut | output | 1 | Pending first-expiry interrupt |
| rstReqOut | output | 1 | Reset request after second expiry |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, the reset-request pulse variant and the all-ones reset load. Because software can write load values of 0 to 11, the bench drives full expiry, second-expiry reset and reload sequences within a few dozen ticks, and the random phase mixes key writes, locked and unlocked writes, clears colliding with expiries and ticks against a cycle model.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  // Register decode; the software map depends on these offsets
  localparam logic [ADDR_W-1:0] ADDR_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 12'h004;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 12'h00C;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 12'h014;
  localparam logic [ADDR_W-1:0] ADDR_KEY   = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // clear interrupt and reload this cycle
    logic run;    // counter enabled
    logic rstEn;  // second expiry may request reset
  } gtStrobe_t;
endpackage

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [CNT_W-1:0]  curCount,
  input  logic              irqPend,
  output gtStrobe_t         strb,
  output logic [CNT_W-1:0]  loadVal
);
  logic             locked;
  logic [CNT_W-1:0] loadReg;
  logic             runBit;
  logic             rstEnBit;
  logic             writeOpen;

  assign writeOpen = regWe && !locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked   <= 1'b1;
      loadReg  <= LOAD_RST;
      runBit   <= 1'b0;
      rstEnBit <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_KEY)
        locked <= (regWdata != UNLOCK_KEY);
      if (writeOpen && regAddr == ADDR_LOAD)
        loadReg <= regWdata[CNT_W-1:0];
      if (writeOpen && regAddr == ADDR_CTRL) begin
        runBit   <= regWdata[0];
        rstEnBit <= regWdata[1];
      end
    end
  end

  assign strb.clear = writeOpen && (regAddr == ADDR_CLEAR) && regWdata[0];
  assign strb.run   = runBit;
  assign strb.rstEn = rstEnBit;
  assign loadVal    = loadReg;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_LOAD:  regRdata[CNT_W-1:0] = loadReg;
      ADDR_COUNT: regRdata[CNT_W-1:0] = curCount;
      ADDR_CTRL:  regRdata[1:0] = {rstEnBit, runBit};
      ADDR_STAT:  regRdata[0] = irqPend;
      ADDR_KEY:   regRdata[0] = locked;
      default:    regRdata = '0;
    endcase
  end

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && regWe && regAddr != ADDR_KEY) |=> ($stable(loadReg) && $stable(runBit) && $stable(rstEnBit)));

  // R1
  key_unlocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_KEY && regWdata == UNLOCK_KEY) |=> !locked);
endmodule

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter bit RST_HOLD = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  gtStrobe_t        strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             irqPend,
  output logic             rstReq
);
  logic atZero;
  logic stepNow;
  logic expire;
  logic rstFire;

  assign atZero  = (count == '0);
  assign stepNow = strb.run && tickEn && !strb.clear;
  assign expire  = stepNow && atZero;
  assign rstFire = expire && irqPend && strb.rstEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= LOAD_RST;
      irqPend <= 1'b0;
    end else if (strb.clear) begin
      count   <= loadVal;
      irqPend <= 1'b0;
    end else if (stepNow) begin
      if (atZero) begin
        count   <= loadVal;
        irqPend <= 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  generate
    if (RST_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
        if (!rstN) rstReq <= 1'b0;
        else       rstReq <= rstReq || rstFire;
      end
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (!rstN) rstReq <= 1'b0;
        else       rstReq <= rstFire;
      end
    end
  endgenerate

  // R6
  reset_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> ($past(irqPend) && $past(strb.rstEn)));

  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> $stable(count));

  // R5
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!irqPend && count == $past(loadVal)));

  // R4
  irq_from_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> ($past(count) == '0));

  // R9
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && tickEn && !strb.clear && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1,
  parameter bit RST_HOLD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              rstReqOut
);
  gtStrobe_t        strb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;
  logic             irqPend;

  guard_timer_ctrl #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .curCount(count),
    .irqPend(irqPend), .strb(strb), .loadVal(loadVal)
  );

  guard_timer_dp #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST), .RST_HOLD(RST_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .loadVal(loadVal),
    .count(count), .irqPend(irqPend), .rstReq(rstReqOut)
  );

  assign irqOut = irqPend;
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut, rstReqOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #2 clk = ~clk;

  guard_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  // Reference model built from the requirements
  logic        mLocked, mRun, mRstEn, mIrq, mRst;
  logic [31:0] mLoad, mCount;

  always @(posedge clk) begin
    logic clr, step;
    if (!rstN) begin
      mLocked = 1; mRun = 0; mRstEn = 0; mIrq = 0; mRst = 0;
      mLoad = 32'hFFFFFFFF; mCount = 32'hFFFFFFFF;
    end else begin
      clr  = regWe && !mLocked && regAddr == 12'h00C && regWdata[0];
      step = mRun && tickEn && !clr;
      mRst = step && mCount == 0 && mIrq && mRstEn;
      if (clr) begin mCount = mLoad; mIrq = 0; end
      else if (step) begin
        if (mCount == 0) begin mCount = mLoad; mIrq = 1; end
        else mCount = mCount - 1;
      end
      if (regWe && !mLocked && regAddr == 12'h000) mLoad = regWdata;
      if (regWe && !mLocked && regAddr == 12'h008) begin mRun = regWdata[0]; mRstEn = regWdata[1]; end
      if (regWe && regAddr == 12'hC00) mLocked = (regWdata != KEY);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle of stimulus, ending at the next falling edge
  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d, input logic t);
    regWe = we; regAddr = a; regWdata = d; tickEn = t;
    @(negedge clk);
    regWe = 0; tickEn = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    regWe = 0; regAddr = a; #1; v = regRdata;
  endtask

  function automatic logic [11:0] pickAddr(input int k);
    case (k)
      0: return 12'h000; 1: return 12'h008; 2: return 12'h00C;
      3: return 12'hC00; 4: return 12'h010; default: return 12'h004;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    rd(12'h000, v); chk("R10 load", v, 32'hFFFFFFFF);
    rd(12'h004, v); chk("R10 count", v, 32'hFFFFFFFF);
    rd(12'h008, v); chk("R10 ctrl", v, 0);
    chk("R10 irq", irqOut, 0); chk("R10 rst", rstReqOut, 0);
    rd(12'hC00, v); chk("R1 locked after reset", v, 1);
    // R2 locked writes ignored
    cyc(1, 12'h000, 5, 0);
    rd(12'h000, v); chk("R2 load", v, 32'hFFFFFFFF);
    cyc(1, 12'h008, 1, 1); cyc(0, 12'h004, 0, 1);
    rd(12'h008, v); chk("R2 ctrl", v, 0);
    rd(12'h004, v); chk("R2 count", v, 32'hFFFFFFFF);
    // R1 unlock
    cyc(1, 12'hC00, KEY, 0);
    rd(12'hC00, v); chk("R1 unlocked", v, 0);
    // R8 / R5
    cyc(1, 12'h000, 3, 0);
    rd(12'h004, v); chk("R8 count unchanged", v, 32'hFFFFFFFF);
    cyc(1, 12'h00C, 2, 0);
    rd(12'h004, v); chk("R5 bit0 zero no effect", v, 32'hFFFFFFFF);
    cyc(1, 12'h00C, 1, 0);
    rd(12'h004, v); chk("R5 clear reload", v, 3);
    rd(12'h014, v); chk("R3 status clear", v, 0);
    // R9 counting
    cyc(1, 12'h008, 1, 0);
    cyc(0, 12'h004, 0, 1); cyc(0, 12'h004, 0, 1); cyc(0, 12'h004, 0, 1);
    rd(12'h004, v); chk("R9 count at zero", v, 0);
    cyc(0, 12'h004, 0, 0);
    rd(12'h004, v); chk("R9 no tick hold", v, 0);
    // R4 first expiry
    cyc(0, 12'h004, 0, 1);
    chk("R4 irq set", irqOut, 1);
    rd(12'h004, v); chk("R4 reload", v, 3);
    rd(12'h014, v); chk("R3 status pending", v, 1);
    chk("R6 no reset first expiry", rstReqOut, 0);
    // R6 second expiry with reset enabled
    cyc(1, 12'h008, 3, 0);
    cyc(1, 12'h000, 2, 0);
    rd(12'h004, v); chk("R8 load write keeps count", v, 3);
    repeat (3) cyc(0, 12'h004, 0, 1);
    chk("R6 no reset yet", rstReqOut, 0);
    cyc(0, 12'h004, 0, 1);
    chk("R6 reset request", rstReqOut, 1);
    rd(12'h004, v); chk("R6 reload", v, 2);
    cyc(0, 12'h004, 0, 0);
    chk("R6 one cycle pulse", rstReqOut, 0);
    // R7 freeze and resume
    cyc(1, 12'h008, 0, 0);
    repeat (3) cyc(0, 12'h004, 0, 1);
    rd(12'h004, v); chk("R7 frozen", v, 2);
    cyc(1, 12'h008, 1, 0);
    cyc(0, 12'h004, 0, 1);
    rd(12'h004, v); chk("R7 resume", v, 1);
    // R6 reset disabled: second expiry only reloads
    cyc(0, 12'h004, 0, 1); cyc(0, 12'h004, 0, 1);
    chk("R6 disabled no reset", rstReqOut, 0);
    rd(12'h004, v); chk("R6 disabled reload", v, 2);
    // R1 relock, R2 clear ignored
    cyc(1, 12'hC00, 32'h0, 0);
    rd(12'hC00, v); chk("R1 relocked", v, 1);
    cyc(1, 12'h00C, 1, 0);
    chk("R2 clear ignored", irqOut, 1);
    rd(12'h010, v); chk("R3 unmapped reads zero", v, 0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [31:0] d;
      rd(12'h004, v);
      chk("R9 count", v, mCount);
      chk("R4 irq", irqOut, mIrq);
      chk("R6 rst", rstReqOut, mRst);
      rd(12'hC00, v); chk("R1 lock", v, {31'b0, mLocked});
      k = $urandom % 16;
      if (k < 2)        cyc(1, 12'hC00, KEY, $urandom % 4 != 0);
      else if (k == 2)  cyc(1, 12'hC00, $urandom, $urandom % 4 != 0);
      else begin
        d = (k < 6) ? ($urandom % 12) : (k < 9) ? ($urandom % 4) | 1 : $urandom;
        if (k < 12) cyc(1, pickAddr(k < 6 ? 0 : k < 9 ? 1 : k < 11 ? 2 : 4), d, $urandom % 4 != 0);
        else        cyc(0, 12'h004, 0, $urandom % 4 != 0);
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule